// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretcher and Watchdog

This block watches a digital supply-good flag from an external comparator and holds the system in reset while the supply is out of range. After the supply comes back, it keeps reset asserted for a fixed stretch. It also runs a watchdog on a software-toggled input, which reaches the block already decoded into low, high or floating.

The watchdog uses a long period for its first window after every reset, even when the short option is selected. It moves to the normal period only once software has shown activity. A timeout drives the watchdog status output low and starts a complete reset pulse of the same length as a power-up stretch. If the input stays stuck, a new pulse follows every long period. A floating input turns the watchdog off.

Timing comes from one strobe input, `tb_tick`. The strobe has two uses:
- In external-clock mode, each strobe is one unit of time.
- In internal mode, the strobe runs at a fixed rate and a prescaler divides it down to millisecond units.

All pins are plain control and status levels. There is no data stream, so no valid/ready handshake or back-pressure applies.

Top module: `sup_ctrl`

## Requirements
- R1: While `supply_ok` is 0, `rst_n_o` is 0 in the same cycle, without waiting for a clock edge. `low_line_n_o` equals `supply_ok` at all times.
- R2: After `supply_ok` rises, or after the block's own reset `rst_n` is released with the supply good, `rst_n_o` stays 0 until the reset count completes. The count is `EXT_RST_CYC` strobes in external mode (`ext_mode`=1) or `RST_MS` units in internal mode.
- R3: In external mode, the normal watchdog period is `EXT_WD_CYC` strobes. The first period after a reset is `EXT_WD_FIRST_CYC` strobes.
- R4: In internal mode with `short_sel`=1, the normal period is `WD_SHORT_MS` units and the first period after a reset is `WD_LONG_MS` units.
- R5: In internal mode with `short_sel`=0, both the normal period and the first period are `WD_LONG_MS` units.
- R6: A change of `wdi_level` between low and high restarts the watchdog count. The normal period takes effect only after the first such transition following reset release. A change between floating and a level is not a transition.
- R7: `wdi_level` encoding: 2'b00 is low, 2'b01 is high, and bit 1 set means floating. While the input reads floating, the watchdog never times out.
- R8: A watchdog timeout drives `wdo_n_o` to 0 and asserts `rst_n_o` for a full reset count. With the input stuck, a further timeout follows after each first period.
- R9: `wdo_n_o` returns to 1 on the next low/high transition of `wdi_level`, even during a reset pulse. It is also 1 from the first clock edge at which `supply_ok` is 0.
- R10: The watchdog count restarts from zero at the end of every reset, whatever caused it. The watchdog does nothing while `supply_ok` is 0.
- R11: `rst_o` is always the exact complement of `rst_n_o`.
- R12: Reset and watchdog counts advance only on `tb_tick` strobes. In internal mode, one unit equals `PRESCALE` strobes. The watchdog input passes through two synchronising flops, so a transition takes effect at the third clock edge after it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own state |
| supply_ok | input | 1 | Supply-above-threshold flag from the comparator |
| wdi_level | input | 2 | Decoded watchdog input: 00 low, 01 high, 1x floating |
| tb_tick | input | 1 | Timebase strobe, one clock wide per event |
| ext_mode | input | 1 | 1 selects counting of external strobes; 0 selects prescaled millisecond units |
| short_sel | input | 1 | In internal mode, 1 selects the short normal watchdog period |
| rst_n_o | output | 1 | Active-low reset to the system |
| rst_o | output | 1 | Active-high reset, the complement of `rst_n_o` |
| low_line_n_o | output | 1 | Low when the supply is below threshold, with no delay |
| wdo_n_o | output | 1 | Watchdog status, low after a timeout |

## Verification
The hardest state to reach from the ports is the return to the long first period after the short normal period has already been in use. Reaching it takes four steps:
- Start a fresh supply cycle.
- Toggle the watchdog input once during the long first window, so the short period takes effect.
- Let the input stick, so that timeout produces a reset pulse.
- After that pulse, measure the next window and check that it is long again.

A second hard case is a floating input that settles to a level without any transition. In that case the first window must stay long. The stimulus reaches it by floating the input through the whole stretch and then driving it low.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    WDI_LOW   = 2'b00,
    WDI_HIGH  = 2'b01,
    WDI_FLT   = 2'b10,
    WDI_FLT_B = 2'b11
  } wdi_lvl_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sup_prescale.sv
module sup_prescale #(
  parameter int unsigned PRESCALE = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tb_tick,
  input  logic ext_mode,
  output logic unit
);

  generate
    if (PRESCALE <= 1) begin : g_pass
      // Strobe is already one unit in both modes.
      assign unit = tb_tick;
    end else begin : g_div
      localparam int unsigned PW = $clog2(PRESCALE);
      logic [PW-1:0] pcnt;
      logic          wrap;

      assign wrap = (pcnt == PW'(PRESCALE - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pcnt <= '0;
        end else if (tb_tick && !ext_mode) begin
          pcnt <= wrap ? '0 : pcnt + 1'b1;
        end
      end

      // External mode: every strobe counts. Internal: one per PRESCALE strobes.
      assign unit = tb_tick & (ext_mode | wrap);
    end
  endgenerate

endmodule

// File: rtl/sup_wdi_sync.sv
module sup_wdi_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wdi_level,
  output logic       wd_en,
  output logic       wd_edge
);
  import sup_pkg::*;

  logic [1:0] s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= WDI_FLT;
      s2   <= WDI_FLT;
      prev <= WDI_FLT;
    end else begin
      s1   <= wdi_level;
      s2   <= s1;
      prev <= s2;
    end
  end

  // Bit 1 set means floating: no watchdog supervision.
  assign wd_en   = ~s2[1];
  // Only a low<->high change counts as activity.
  assign wd_edge = ~s2[1] & ~prev[1] & (s2[0] ^ prev[0]);

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int unsigned CW      = 13,
  parameter int unsigned INT_RST = 200,
  parameter int unsigned EXT_RST = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic unit,
  input  logic ext_mode,
  input  logic expire,
  output logic busy
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] period;
  logic          last;

  assign period = ext_mode ? CW'(EXT_RST) : CW'(INT_RST);
  assign last   = (cnt == period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (!supply_ok) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (expire) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && unit) begin
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned CW        = 13,
  parameter int unsigned WD_SHORT  = 100,
  parameter int unsigned WD_LONG   = 1600,
  parameter int unsigned EXT_NORM  = 1024,
  parameter int unsigned EXT_FIRST = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic busy,
  input  logic unit,
  input  logic ext_mode,
  input  logic short_sel,
  input  logic wd_en,
  input  logic wd_edge,
  output logic expire,
  output logic wdo_n
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          first;

  always_comb begin
    if (ext_mode) begin
      limit = first ? CW'(EXT_FIRST) : CW'(EXT_NORM);
    end else if (first || !short_sel) begin
      limit = CW'(WD_LONG);
    end else begin
      limit = CW'(WD_SHORT);
    end
  end

  assign expire = supply_ok & ~busy & wd_en & ~wd_edge & unit
                & (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      first <= 1'b1;
    end else if (!supply_ok || busy) begin
      cnt   <= '0;
      first <= 1'b1;
    end else if (wd_edge) begin
      cnt   <= '0;
      first <= 1'b0;
    end else if (!wd_en || expire) begin
      cnt <= '0;
    end else if (unit) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Status flag: dropped by a timeout, raised by activity or supply loss.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdo_n <= 1'b1;
    end else if (!supply_ok) begin
      wdo_n <= 1'b1;
    end else if (expire) begin
      wdo_n <= 1'b0;
    end else if (wd_edge) begin
      wdo_n <= 1'b1;
    end
  end

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl #(
  parameter int unsigned PRESCALE         = 1000,
  parameter int unsigned RST_MS           = 200,
  parameter int unsigned WD_SHORT_MS      = 100,
  parameter int unsigned WD_LONG_MS       = 1600,
  parameter int unsigned EXT_RST_CYC      = 2048,
  parameter int unsigned EXT_WD_CYC       = 1024,
  parameter int unsigned EXT_WD_FIRST_CYC = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic [1:0] wdi_level,
  input  logic       tb_tick,
  input  logic       ext_mode,
  input  logic       short_sel,
  output logic       rst_n_o,
  output logic       rst_o,
  output logic       low_line_n_o,
  output logic       wdo_n_o
);
  import sup_pkg::*;

  localparam int unsigned MAXP = max2(max2(max2(RST_MS, WD_SHORT_MS), max2(WD_LONG_MS, EXT_RST_CYC)),
                                      max2(EXT_WD_CYC, EXT_WD_FIRST_CYC));
  localparam int unsigned CW   = $clog2(MAXP + 1);

  logic unit;
  logic wd_en;
  logic wd_edge;
  logic busy;
  logic expire;

  sup_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_tick  (tb_tick),
    .ext_mode (ext_mode),
    .unit     (unit)
  );

  sup_wdi_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdi_level (wdi_level),
    .wd_en     (wd_en),
    .wd_edge   (wd_edge)
  );

  sup_reset_gen #(
    .CW      (CW),
    .INT_RST (RST_MS),
    .EXT_RST (EXT_RST_CYC)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .unit      (unit),
    .ext_mode  (ext_mode),
    .expire    (expire),
    .busy      (busy)
  );

  sup_watchdog #(
    .CW        (CW),
    .WD_SHORT  (WD_SHORT_MS),
    .WD_LONG   (WD_LONG_MS),
    .EXT_NORM  (EXT_WD_CYC),
    .EXT_FIRST (EXT_WD_FIRST_CYC)
  ) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .busy      (busy),
    .unit      (unit),
    .ext_mode  (ext_mode),
    .short_sel (short_sel),
    .wd_en     (wd_en),
    .wd_edge   (wd_edge),
    .expire    (expire),
    .wdo_n     (wdo_n_o)
  );

  // Supply loss asserts reset without waiting for a clock edge.
  assign rst_n_o      = supply_ok & ~busy;
  assign rst_o        = ~rst_n_o;
  assign low_line_n_o = supply_ok;

endmodule

// File: rtl/sup_ctrl_chk.sv
module sup_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic [1:0] wdi_level,
  input logic       rst_n_o,
  input logic       low_line_n_o,
  input logic       wdo_n_o
);

  // R1: supply low means reset asserted and low-line low
  a_r1_supply_low_resets: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!rst_n_o && !low_line_n_o));

  // R2: reset is still held in the cycle the supply returns
  a_r2_stretch_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !$past(supply_ok)) |-> !rst_n_o);

  // R8: a fall of the watchdog flag comes with an asserted reset
  a_r8_timeout_pulses_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdo_n_o) |-> !rst_n_o);

  // R9: watchdog flag forced high after a clock with the supply low
  a_r9_wdo_high_on_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> wdo_n_o);

  // R7: a floating input never lets the watchdog pull reset
  a_r7_float_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && $past(supply_ok) && $past(rst_n_o)
     && $past(wdi_level[1], 1) && $past(wdi_level[1], 2)
     && $past(wdi_level[1], 3) && $past(wdi_level[1], 4)) |-> rst_n_o);

endmodule

bind sup_ctrl sup_ctrl_chk i_sup_ctrl_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_ok    (supply_ok),
  .wdi_level    (wdi_level),
  .rst_n_o      (rst_n_o),
  .low_line_n_o (low_line_n_o),
  .wdo_n_o      (wdo_n_o)
);

// File: tb/test_sup_ctrl.sv
module test_sup_ctrl;

  localparam int P_PRE = 2;
  localparam int P_RST = 6;   // internal units
  localparam int P_WDS = 4;
  localparam int P_WDL = 12;
  localparam int P_XR  = 8;   // external strobes
  localparam int P_XN  = 5;
  localparam int P_XF  = 10;

  localparam logic [1:0] LV_LOW = 2'b00, LV_HIGH = 2'b01, LV_FLT = 2'b10;

  localparam logic [1:0] OP_STRETCH = 2'd0, OP_FIRST = 2'd1, OP_NORMAL = 2'd2, OP_PULSE = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic       ext;
    logic       shrt;
    logic [7:0] exp;
    logic [1:0] tol;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  // Internal entries allow one cycle of prescaler phase below the nominal count.
  localparam vec_t VECS [NV] = '{
    '{OP_STRETCH, 1'b1, 1'b0, 8'(P_XR),              2'd0, 4'd2},  // R2
    '{OP_STRETCH, 1'b0, 1'b1, 8'(P_PRE*P_RST),       2'd1, 4'd2},  // R2 with R12 prescale
    '{OP_FIRST,   1'b1, 1'b1, 8'(P_XF),              2'd0, 4'd3},  // R3
    '{OP_FIRST,   1'b0, 1'b1, 8'(P_PRE*P_WDL),       2'd1, 4'd4},  // R4
    '{OP_FIRST,   1'b0, 1'b0, 8'(P_PRE*P_WDL),       2'd1, 4'd5},  // R5
    '{OP_NORMAL,  1'b1, 1'b0, 8'(3+P_XN),            2'd0, 4'd6},  // R6 and R3
    '{OP_NORMAL,  1'b0, 1'b1, 8'(3+P_PRE*P_WDS),     2'd1, 4'd4},  // R4
    '{OP_NORMAL,  1'b0, 1'b0, 8'(3+P_PRE*P_WDL),     2'd1, 4'd5},  // R5
    '{OP_PULSE,   1'b1, 1'b0, 8'(P_XR),              2'd0, 4'd8},  // R8
    '{OP_PULSE,   1'b0, 1'b0, 8'(P_PRE*P_RST),       2'd1, 4'd8}   // R8
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b1;
  logic [1:0] wdi_level = LV_LOW;
  logic       tb_tick = 1'b1;
  logic       ext_mode = 1'b1;
  logic       short_sel = 1'b0;
  logic       rst_n_o, rst_o, low_line_n_o, wdo_n_o;

  int checks = 0;
  int errors = 0;
  int comp_err = 0;
  int ll_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sup_ctrl #(
    .PRESCALE(P_PRE), .RST_MS(P_RST), .WD_SHORT_MS(P_WDS), .WD_LONG_MS(P_WDL),
    .EXT_RST_CYC(P_XR), .EXT_WD_CYC(P_XN), .EXT_WD_FIRST_CYC(P_XF)
  ) i_sup_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdi_level(wdi_level),
    .tb_tick(tb_tick), .ext_mode(ext_mode), .short_sel(short_sel),
    .rst_n_o(rst_n_o), .rst_o(rst_o), .low_line_n_o(low_line_n_o), .wdo_n_o(wdo_n_o)
  );

  // R11 and R1 monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_o === rst_n_o) comp_err++;
    if (low_line_n_o !== supply_ok) ll_err++;
  end

  task automatic check(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_rst(input logic level, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (rst_n_o !== level && n < 1000);
  endtask

  task automatic fresh_start(input logic ext, input logic shrt);
    @(negedge clk);
    supply_ok = 1'b0;
    wdi_level = LV_LOW;
    tb_tick   = 1'b1;
    ext_mode  = ext;
    short_sel = shrt;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
  endtask

  task automatic toggle();
    wdi_level = (wdi_level == LV_LOW) ? LV_HIGH : LV_LOW;
  endtask

  initial begin
    int n;
    int lows;
    string tag;
    // Reset state
    repeat (2) @(negedge clk);
    check("R2 reset state rst_n_o", int'(rst_n_o), 0, 0);
    check("R11 reset state rst_o", int'(rst_o), 1, 1);
    check("R9 reset state wdo_n_o", int'(wdo_n_o), 1, 1);
    rst_n = 1'b1;
    wait_rst(1'b1, n);
    check("R2 stretch after block reset", n, P_XR, P_XR);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      tag = $sformatf("R%0d vector %0d", v.req, i);
      fresh_start(v.ext, v.shrt);
      wait_rst(1'b1, n);
      case (v.op)
        OP_FIRST:  wait_rst(1'b0, n);
        OP_NORMAL: begin toggle(); wait_rst(1'b0, n); end
        OP_PULSE:  begin wait_rst(1'b0, n); wait_rst(1'b1, n); end
        default: ;
      endcase
      check(tag, n, int'(v.exp) - int'(v.tol), int'(v.exp));
    end

    // R7: floating input disables the watchdog; settling to a level is no transition (R6)
    fresh_start(1'b1, 1'b0);
    wdi_level = LV_FLT;
    wait_rst(1'b1, n);
    lows = 0;
    repeat (40) begin
      @(negedge clk);
      if (!rst_n_o) lows++;
    end
    check("R7 floating input no reset", lows, 0, 0);
    wdi_level = LV_LOW;
    wait_rst(1'b0, n);
    check("R6 float to low keeps long first window", n, 2 + P_XF, 2 + P_XF);
    check("R8 timeout drops wdo_n_o", int'(wdo_n_o), 0, 0);

    // R9: next transition raises the watchdog flag after the sync delay, even in reset
    toggle();
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!wdo_n_o && n < 100);
    check("R9 wdo_n_o high after transition", n, 3, 3);
    wait_rst(1'b1, n);
    wait_rst(1'b0, n);
    check("R8 stuck input repeats after long period", n, P_XF, P_XF);
    wait_rst(1'b1, n);
    check("R8 timeout pulse full length", n, P_XR, P_XR);
    wait_rst(1'b0, n);
    check("R8 second repeat long period", n, P_XF, P_XF);
    wait_rst(1'b1, n);

    // R1 / R9 / R10: supply drop during operation
    wait_rst(1'b0, n);            // wdo now low after timeout
    wait_rst(1'b1, n);
    check("R8 wdo_n_o still low before drop", int'(wdo_n_o), 0, 0);
    supply_ok = 1'b0;
    #1;
    check("R1 reset asserted without clock", int'(rst_n_o), 0, 0);
    check("R1 low_line follows supply", int'(low_line_n_o), 0, 0);
    @(posedge clk); @(negedge clk);
    check("R9 wdo_n_o forced high on low supply", int'(wdo_n_o), 1, 1);
    repeat (30) @(negedge clk);
    check("R10 no watchdog action while supply low", int'(wdo_n_o), 1, 1);
    supply_ok = 1'b1;
    wait_rst(1'b1, n);
    check("R10 stretch after supply return", n, P_XR, P_XR);
    wait_rst(1'b0, n);
    check("R10 count restarted with long first window", n, P_XF, P_XF);

    // R12: counts advance only on strobes
    fresh_start(1'b1, 1'b0);
    tb_tick = 1'b0;
    lows = 0;
    repeat (30) begin
      @(negedge clk);
      if (!rst_n_o) lows++;
    end
    check("R12 no strobes holds reset", lows, 30, 30);
    tb_tick = 1'b1;
    wait_rst(1'b1, n);
    check("R12 stretch counts strobes only", n, P_XR, P_XR);

    // R6: short period in use, then after its timeout the first window is long again
    toggle();
    wait_rst(1'b0, n);
    check("R6 normal period after transition", n, 3 + P_XN, 3 + P_XN);
    wait_rst(1'b1, n);
    wait_rst(1'b0, n);
    check("R6 first window long again after reset", n, P_XF, P_XF);

    check("R11 rst_o complement monitor", comp_err, 0, 0);
    check("R1 low_line monitor", ll_err, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule